// File: doc/BRIEF.md
# Gate Pulse On-Time Limiter

This block sits between a converter's switching controller and the gate driver of its second-stage switch. It caps how long that switch can stay on. When the controller raises its turn-on request, the gate output goes high on the next clock edge. The gate goes low again when the request drops or when a programmable on-time budget runs out, whichever happens first. A one-cycle flag reports each pulse that the budget ended instead of the request.

The budget is set by an 8-bit unsigned code N. It is measured in 50 ns ticks, and the limit is (8·N + 7) ticks. That gives 350 ns at N = 0 and 102.35 µs at N = 255. The ticks are made from a 100 MHz clock by a divide-by-5 prescaler. The prescaler phase restarts with every new pulse, so the cutoff always falls a whole number of ticks after the rising edge.

A new code can be written at any time. It is captured only when a pulse starts, so the pulse already running keeps its budget. After a forced cutoff the gate stays low until the request has been seen low on at least one clock edge.

Top module: `gate_ontime_limiter`

## Requirements
- R1: While reset is asserted and immediately after it is released, `gate_o` and `limit_hit_o` are both 0.
- R2: When no pulse is active, the first clock edge that samples `req_i` high drives `gate_o` high.
- R3: While the gate is high, the first clock edge that samples `req_i` low drives `gate_o` low without pulsing `limit_hit_o`. This also holds when that edge is the one on which the budget would run out.
- R4: With the request held long enough, `gate_o` stays high for exactly 5·(8·N + 7) clock cycles, where N is the 8-bit unsigned code captured at the start of the pulse.
- R5: At N = 0 the gate's maximum high time is 35 cycles, and at N = 255 it is 10235 cycles.
- R6: `limit_hit_o` is high for exactly one cycle, and only in the first cycle in which `gate_o` is low after a budget cutoff.
- R7: After a cutoff, `gate_o` stays low for as long as `req_i` stays high. Once `req_i` has been sampled low on at least one edge, a request that rises again starts a new pulse with the full budget.
- R8: A code written with `dur_wr_i` while a pulse is running does not change that pulse's length. The new code applies from the next pulse on, and a code written while idle applies to the next pulse.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 100 MHz system clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| dur_wr_i | input | 1 | Write strobe for the duration code |
| dur_data_i | input | 8 | Duration code N, unsigned |
| req_i | input | 1 | Turn-on request from the switching controller |
| gate_o | output | 1 | Gate drive enable |
| limit_hit_o | output | 1 | One-cycle pulse: the pulse was ended by the budget |

## Verification
Requests shorter than the budget, exactly equal to it, and longer than it are applied. Together they show whether the request or the budget ended the pulse, and they cover the tie case in which the request wins. Codes 0 and 255 check the two ends of the affine limit, and random codes with random hold times check the tick multiple in between. Holding the request well past a cutoff and then dropping it for a single cycle separates correct lockout from a premature retrigger. A write placed in the middle of a pulse shows whether the code is captured at the start of the pulse or read continuously.

// File: rtl/gtl_pkg.sv
package gtl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ON   = 2'd1,
        ST_LOCK = 2'd2
    } gtl_state_e;

endpackage

// File: rtl/gtl_tick_gen.sv
module gtl_tick_gen #(
    parameter int unsigned CLK_DIV = 5
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clr_i,
    input  logic run_i,
    output logic tick_o
);
    localparam int unsigned DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);

    typedef struct packed {
        logic [DIV_W-1:0] div;
    } tick_t;

    tick_t tick_d, tick_q;

    always_comb begin
        tick_d = tick_q;
        tick_o = 1'b0;
        if (clr_i) begin
            tick_d.div = '0;
        end else if (run_i) begin
            if (tick_q.div == DIV_LAST) begin
                tick_d.div = '0;
                tick_o     = 1'b1;
            end else begin
                tick_d.div = tick_q.div + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            tick_q <= '0;
        end else begin
            tick_q <= tick_d;
        end
    end

endmodule

// File: rtl/gtl_limit_reg.sv
module gtl_limit_reg #(
    parameter int unsigned DUR_W   = 8,
    parameter int unsigned STEP    = 8,
    parameter int unsigned OFFSET  = 7,
    parameter int unsigned LIM_W   = 11,
    parameter int unsigned DUR_RST = 0
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_i,
    input  logic [DUR_W-1:0] wdata_i,
    input  logic             load_i,
    output logic [LIM_W-1:0] lim_o
);
    typedef struct packed {
        logic [DUR_W-1:0] dur;
        logic [LIM_W-1:0] lim;
    } lreg_t;

    lreg_t lreg_d, lreg_q;

    always_comb begin
        lreg_d = lreg_q;
        // the budget is frozen from the stored code before a same-edge write lands
        if (load_i) begin
            lreg_d.lim = LIM_W'(STEP * 32'(lreg_q.dur) + OFFSET);
        end
        if (wr_i) begin
            lreg_d.dur = wdata_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            lreg_q.dur <= DUR_W'(DUR_RST);
            lreg_q.lim <= LIM_W'(STEP * DUR_RST + OFFSET);
        end else begin
            lreg_q <= lreg_d;
        end
    end

    assign lim_o = lreg_q.lim;

endmodule

// File: rtl/gate_ontime_limiter.sv
module gate_ontime_limiter
    import gtl_pkg::*;
#(
    parameter int unsigned CLK_DIV = 5,
    parameter int unsigned DUR_W   = 8,
    parameter int unsigned STEP    = 8,
    parameter int unsigned OFFSET  = 7,
    parameter int unsigned DUR_RST = 0
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             dur_wr_i,
    input  logic [DUR_W-1:0] dur_data_i,
    input  logic             req_i,
    output logic             gate_o,
    output logic             limit_hit_o
);
    localparam int unsigned LIM_MAX = STEP * ((2 ** DUR_W) - 1) + OFFSET;
    localparam int unsigned LIM_W   = $clog2(LIM_MAX + 1);

    typedef struct packed {
        gtl_state_e       state;
        logic [LIM_W-1:0] cnt;
        logic             gate;
        logic             hit;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic             start;
    logic             tick;
    logic [LIM_W-1:0] lim;
    logic [LIM_W-1:0] cnt_inc;

    assign start   = (ctl_q.state == ST_IDLE) && req_i;
    assign cnt_inc = ctl_q.cnt + 1'b1;

    gtl_tick_gen #(
        .CLK_DIV (CLK_DIV)
    ) tick_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (start),
        .run_i  (ctl_q.state == ST_ON),
        .tick_o (tick)
    );

    gtl_limit_reg #(
        .DUR_W   (DUR_W),
        .STEP    (STEP),
        .OFFSET  (OFFSET),
        .LIM_W   (LIM_W),
        .DUR_RST (DUR_RST)
    ) limit_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_i    (dur_wr_i),
        .wdata_i (dur_data_i),
        .load_i  (start),
        .lim_o   (lim)
    );

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.hit = 1'b0;
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (req_i) begin
                    ctl_d.state = ST_ON;
                    ctl_d.cnt   = '0;
                    ctl_d.gate  = 1'b1;
                end
            end
            ST_ON: begin
                if (!req_i) begin
                    // request release wins a tie with the budget
                    ctl_d.state = ST_IDLE;
                    ctl_d.gate  = 1'b0;
                end else if (tick) begin
                    ctl_d.cnt = cnt_inc;
                    if (cnt_inc == lim) begin
                        ctl_d.state = ST_LOCK;
                        ctl_d.gate  = 1'b0;
                        ctl_d.hit   = 1'b1;
                    end
                end
            end
            ST_LOCK: begin
                if (!req_i) begin
                    ctl_d.state = ST_IDLE;
                end
            end
            default: begin
                ctl_d.state = ST_IDLE;
                ctl_d.gate  = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ctl_q.state <= ST_IDLE;
            ctl_q.cnt   <= '0;
            ctl_q.gate  <= 1'b0;
            ctl_q.hit   <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign gate_o      = ctl_q.gate;
    assign limit_hit_o = ctl_q.hit;

endmodule

// File: rtl/gate_ontime_limiter_chk.sv
module gate_ontime_limiter_chk #(
    parameter int unsigned MAX_CYC = 10235
) (
    input logic clk_i,
    input logic rst_ni,
    input logic req_i,
    input logic gate_o,
    input logic limit_hit_o
);
    int unsigned hi_cnt_q;
    logic        lock_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            hi_cnt_q <= 0;
            lock_q   <= 1'b0;
        end else begin
            hi_cnt_q <= gate_o ? hi_cnt_q + 1 : 0;
            if (!req_i) begin
                lock_q <= 1'b0;
            end else if (limit_hit_o) begin
                lock_q <= 1'b1;
            end
        end
    end

    always @(posedge clk_i) begin
        if (!rst_ni) begin
            AST_RESET_QUIET: assert (!gate_o && !limit_hit_o); // R1
        end
    end

    AST_RISE_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(gate_o) |-> $past(req_i)); // R2

    AST_DROP_ON_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (gate_o && !req_i) |=> (!gate_o && !limit_hit_o)); // R3

    AST_WIDTH_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        gate_o |-> (hi_cnt_q < MAX_CYC)); // R4

    AST_HIT_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        limit_hit_o |=> !limit_hit_o); // R6

    AST_HIT_AT_CUTOFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        limit_hit_o |-> $fell(gate_o)); // R6

    AST_LOCKOUT_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lock_q |-> !gate_o); // R7

endmodule

bind gate_ontime_limiter gate_ontime_limiter_chk #(
    .MAX_CYC (CLK_DIV * LIM_MAX)
) chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .gate_o      (gate_o),
    .limit_hit_o (limit_hit_o)
);

// File: tb/gate_ontime_limiter_tb.sv
module gate_ontime_limiter_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dur_wr = 1'b0;
    logic [7:0] dur_data = '0;
    logic       req = 1'b0;
    logic       gate;
    logic       hit;

    int n_cmp = 0;
    int n_bad = 0;
    int cur_n = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    gate_ontime_limiter dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .dur_wr_i    (dur_wr),
        .dur_data_i  (dur_data),
        .req_i       (req),
        .gate_o      (gate),
        .limit_hit_o (hit)
    );

    function automatic int budget_cycles(int n);
        return 5 * (8 * n + 7);
    endfunction

    function automatic int exp_width(int n, int h);
        return (h < budget_cycles(n)) ? h : budget_cycles(n);
    endfunction

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic write_dur(int v);
        @(negedge clk);
        dur_wr   = 1'b1;
        dur_data = 8'(v);
        @(negedge clk);
        dur_wr = 1'b0;
        cur_n  = v;
    endtask

    // request held for h rising edges, then low; idle >= 1 trailing samples
    task automatic do_pulse(int h, int idle, int wr_at, int wr_val, string tag);
        int lc      = budget_cycles(cur_n);
        int w       = 0;
        int hits    = 0;
        int fall    = -1;
        int hit_idx = -1;
        int first   = 0;
        @(negedge clk);
        req = 1'b1;
        for (int i = 0; i < h + idle; i++) begin
            @(negedge clk);
            dur_wr = 1'b0;
            if (i == 0) first = int'(gate);
            if (gate) w++;
            else if (fall < 0 && w > 0) fall = i;
            if (hit) begin
                hits++;
                if (hit_idx < 0) hit_idx = i;
            end
            if (i == h - 1) req = 1'b0;
            if (i == wr_at) begin
                dur_wr   = 1'b1;
                dur_data = 8'(wr_val);
            end
        end
        dur_wr = 1'b0;
        chk(first == 1, "R2", "gate after first request edge", first, 1);
        chk(w == exp_width(cur_n, h), tag, "gate high cycles", w, exp_width(cur_n, h));
        if (h > lc) begin
            chk(hits == 1, "R6", "limit pulses", hits, 1);
            chk(hit_idx == fall, "R6", "limit pulse index", hit_idx, fall);
        end else begin
            chk(hits == 0, "R3", "limit pulses on release", hits, 0);
        end
        if (wr_at >= 0) cur_n = wr_val;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        chk(gate == 1'b0, "R1", "gate in reset", int'(gate), 0);
        chk(hit == 1'b0, "R1", "flag in reset", int'(hit), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(gate == 1'b0, "R1", "gate after reset", int'(gate), 0);
        chk(hit == 1'b0, "R1", "flag after reset", int'(hit), 0);

        // default code 0: short, tie, just over, long hold
        do_pulse(10, 2, -1, 0, "R3");
        do_pulse(35, 2, -1, 0, "R3");
        do_pulse(36, 2, -1, 0, "R5");
        do_pulse(120, 1, -1, 0, "R4");
        // retrigger right after lockout with minimal low time
        do_pulse(50, 1, -1, 0, "R7");
        do_pulse(4, 2, -1, 0, "R7");

        // widest budget
        write_dur(255);
        do_pulse(10300, 2, -1, 0, "R5");

        // mid-pulse write keeps the current budget
        write_dur(3);
        do_pulse(200, 2, 20, 1, "R8");
        do_pulse(200, 2, -1, 0, "R8");

        for (int k = 0; k < 30; k++) begin
            int lc;
            if ($urandom_range(2) == 0) write_dur(int'($urandom_range(15)));
            lc = budget_cycles(cur_n);
            do_pulse(1 + int'($urandom_range(lc + 20)), 1 + int'($urandom_range(3)),
                     -1, 0, "R4");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule